// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends pairs of 18-bit two's-complement audio samples, a left and a right value taken at the same instant, over one serial data line. A frame clock marks which channel is on the line, and a bit clock paces the bits. Each channel has its own slot in the frame. The word goes out most significant bit first, and the line is driven low for the rest of the slot.

The block can take either role on the link. As clock master it divides its own master clock to make the bit clock and the frame clock, and it drives both out. As clock slave it takes both clocks as inputs, resamples them in the master-clock domain and acts on their edges. A static select picks one of two framings. In left-justified framing the MSB appears at the frame-clock edge and a high frame clock means left. In I2S framing the MSB comes one bit period after the edge and a low frame clock means left. A mute input holds the line at a fixed level while the framing keeps running.

A sample pair is offered with a one-cycle valid strobe and waits in a holding register. The pair is taken at the start of the next left slot. If no new pair has arrived by then, the last pair is sent again.

Top module: `stereo_serial_tx`

## Requirements
- R1: While reset is held, `sdata` and `bclkOut` are 0.
- R2: In master mode `bclkOut` is the master clock divided by 4 and `lrclkOut` is the master clock divided by 256, so a frame has 64 bit clocks. Both clocks change only together with a falling edge of `bclkOut`.
- R3: In left-justified framing (`i2sFmt`=0) a high frame clock marks the left slot. The MSB is on `sdata` from the frame-clock edge, and the other 17 bits follow MSB first, one per falling bit-clock edge. A 32-bit slot read on rising edges therefore holds {word, 14 zeros}.
- R4: In I2S framing (`i2sFmt`=1) a low frame clock marks the left slot. The first bit of the slot is 0 and the MSB follows one bit period later, so a 32-bit slot holds {0, word, 13 zeros}.
- R5: In slave mode (`masterMode`=0) `bclkOut` and `lrclkOut` stay 0, and the framing follows `bclkIn` and `lrclkIn`. A slot lasts as long as the external frame half. With 24 bit clocks per slot, the 18 data bits are followed by 6 zeros.
- R6: A pair is latched only at the start of a left slot, and both words of one frame come from the same pair. A pair offered during a left slot changes neither word of that frame.
- R7: If no pair has been offered since the last left-slot start, the previous pair is sent again.
- R8: While `mute` is 1, `sdata` holds the mute level (0 by default) from the next cycle on. Framing continues, and after `mute` returns to 0 the next whole frame carries the current pair.
- R9: A pair whose valid strobe falls in the same cycle as a left-slot start is sent in the frame that begins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1: block drives the clocks; 0: clocks are inputs (static) |
| i2sFmt | input | 1 | 0: left-justified framing; 1: I2S framing (static) |
| mute | input | 1 | Hold `sdata` at the mute level |
| sampleValid | input | 1 | One-cycle strobe offering a sample pair |
| sampleLeft | input | 18 | Left sample, two's complement |
| sampleRight | input | 18 | Right sample, two's complement |
| bclkIn | input | 1 | External bit clock (slave mode) |
| lrclkIn | input | 1 | External frame clock (slave mode) |
| bclkOut | output | 1 | Generated bit clock (master mode, else 0) |
| lrclkOut | output | 1 | Generated frame clock (master mode, else 0) |
| sdata | output | 1 | Serial data, changes on falling bit-clock edges |

## Verification
Two events can fall in the same cycle: a new pair arriving on the valid strobe, and the left-slot start that latches the holding register. The bench aligns the two by counting master clocks from an observed left-slot start. It raises `sampleValid` in exactly the cycle before the frame clock turns to left. The next frame read back from the line must carry the new pair and not the previous one. A second case offers a pair in the middle of a left slot and checks that the frame already in flight keeps its old pair in both channels.

// File: rtl/stx_pkg.sv
package stx_pkg;
  // Per-cycle events from the clock/framing control to the shifter
  typedef struct packed {
    logic frameStart;  // frame clock just changed: a new slot begins
    logic leftSlot;    // the slot that begins is the left channel
    logic bitFall;     // bit clock just fell
  } txStrobe_t;
endpackage

// File: rtl/stx_timing.sv
module stx_timing
  import stx_pkg::*;
#(
  parameter int BCLK_DIV  = 4,
  parameter int SLOT_BITS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterMode,
  input  logic      i2sFmt,
  input  logic      bclkIn,
  input  logic      lrclkIn,
  output logic      bclkOut,
  output logic      lrclkOut,
  output txStrobe_t strb
);
  localparam int DIV_W = $clog2(BCLK_DIV);
  localparam int CNT_W = $clog2(BCLK_DIV * SLOT_BITS * 2);

  logic [CNT_W-1:0] divCnt;
  logic [1:0] bSync, lSync;
  logic bPrev, lPrev;
  logic mFall, mFrame, mLeft, sFall, sFrame, sLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bSync  <= '0;
      lSync  <= '0;
      bPrev  <= 1'b0;
      lPrev  <= 1'b0;
    end else begin
      divCnt <= masterMode ? divCnt + 1'b1 : '0;
      bSync  <= {bSync[0], bclkIn};
      lSync  <= {lSync[0], lrclkIn};
      bPrev  <= bSync[1];
      lPrev  <= lSync[1];
    end
  end

  always_comb begin
    // master: events fire in the cycle before the counter wraps its field
    mFall  = &divCnt[DIV_W-1:0];
    mFrame = &divCnt[CNT_W-2:0];
    mLeft  = divCnt[CNT_W-1];
    // slave: events seen on the resampled external clocks
    sFall  = bPrev & ~bSync[1];
    sFrame = lSync[1] ^ lPrev;
    sLeft  = i2sFmt ? ~lSync[1] : lSync[1];
    if (masterMode) begin
      strb.frameStart = mFrame;
      strb.leftSlot   = mLeft;
      strb.bitFall    = mFall;
    end else begin
      strb.frameStart = sFrame;
      strb.leftSlot   = sLeft;
      strb.bitFall    = sFall;
    end
  end

  assign bclkOut  = masterMode & divCnt[DIV_W-1];
  assign lrclkOut = masterMode & (divCnt[CNT_W-1] ^ ~i2sFmt);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int   WORD_W     = 18,
  parameter logic MUTE_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              i2sFmt,
  input  logic              mute,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleLeft,
  input  logic [WORD_W-1:0] sampleRight,
  output logic              sdata
);
  localparam int REM_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] pendL, pendR, heldL, heldR, shReg, nSh, srcL, srcR, word;
  logic [REM_W-1:0]  remBits, nRem;
  logic              pendFull, rawBit, nBit, loadPair;

  always_comb begin
    loadPair = strb.frameStart & strb.leftSlot;
    // a pair arriving in the load cycle bypasses the holding register
    srcL = sampleValid ? sampleLeft  : (pendFull ? pendL : heldL);
    srcR = sampleValid ? sampleRight : (pendFull ? pendR : heldR);
    word = strb.leftSlot ? srcL : heldR;
    nBit = rawBit;
    nSh  = shReg;
    nRem = remBits;
    if (strb.frameStart) begin
      if (i2sFmt) begin
        nBit = 1'b0;
        nSh  = word;
        nRem = REM_W'(WORD_W);
      end else begin
        nBit = word[WORD_W-1];
        nSh  = word << 1;
        nRem = REM_W'(WORD_W - 1);
      end
    end else if (strb.bitFall) begin
      if (remBits != '0) begin
        nBit = shReg[WORD_W-1];
        nSh  = shReg << 1;
        nRem = remBits - 1'b1;
      end else begin
        nBit = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendL    <= '0;
      pendR    <= '0;
      heldL    <= '0;
      heldR    <= '0;
      pendFull <= 1'b0;
      shReg    <= '0;
      remBits  <= '0;
      rawBit   <= 1'b0;
      sdata    <= 1'b0;
    end else begin
      if (sampleValid && !loadPair) begin
        pendL    <= sampleLeft;
        pendR    <= sampleRight;
        pendFull <= 1'b1;
      end else if (loadPair) begin
        pendFull <= 1'b0;
      end
      if (loadPair) begin
        heldL <= srcL;
        heldR <= srcR;
      end
      shReg   <= nSh;
      remBits <= nRem;
      rawBit  <= nBit;
      sdata   <= mute ? MUTE_LEVEL : nBit;
    end
  end
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import stx_pkg::*;
#(
  parameter int   WORD_W     = 18,
  parameter int   BCLK_DIV   = 4,
  parameter int   SLOT_BITS  = 32,
  parameter logic MUTE_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              i2sFmt,
  input  logic              mute,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleLeft,
  input  logic [WORD_W-1:0] sampleRight,
  input  logic              bclkIn,
  input  logic              lrclkIn,
  output logic              bclkOut,
  output logic              lrclkOut,
  output logic              sdata
);
  txStrobe_t strb;

  stx_timing #(.BCLK_DIV(BCLK_DIV), .SLOT_BITS(SLOT_BITS)) u_timing (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .i2sFmt(i2sFmt),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .strb(strb)
  );

  stx_shifter #(.WORD_W(WORD_W), .MUTE_LEVEL(MUTE_LEVEL)) u_shifter (
    .clk(clk), .rstN(rstN), .strb(strb), .i2sFmt(i2sFmt), .mute(mute),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .sdata(sdata)
  );
endmodule

// File: rtl/stx_checks.sv
module stx_checks #(
  parameter logic MUTE_LEVEL = 1'b0
) (
  input logic clk,
  input logic rstN,
  input logic masterMode,
  input logic mute,
  input logic bclkOut,
  input logic lrclkOut,
  input logic sdata
);
  AST_SLAVE_CLOCKS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (bclkOut == 1'b0 && lrclkOut == 1'b0)); // R5

  AST_MUTE_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    mute |=> (sdata == MUTE_LEVEL)); // R8

  AST_BCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $rose(bclkOut)) |=> bclkOut); // R2

  AST_FRAME_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !$stable(lrclkOut)) |-> $fell(bclkOut)); // R2

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !mute && !$past(mute) && !$stable(sdata)) |-> $fell(bclkOut)); // R3
endmodule

bind stereo_serial_tx stx_checks #(.MUTE_LEVEL(MUTE_LEVEL)) u_checks (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .mute(mute),
  .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdata(sdata)
);

// File: tb/stereo_serial_tx_tb.sv
`timescale 1ns/1ps
module stereo_serial_tx_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, masterMode = 1'b1, i2sFmt = 1'b0, mute = 1'b0;
  logic sampleValid = 1'b0, bclkIn = 1'b0, lrclkIn = 1'b0;
  logic [17:0] sampleLeft = '0, sampleRight = '0;
  logic bclkOut, lrclkOut, sdata;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stereo_serial_tx u_dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .i2sFmt(i2sFmt),
    .mute(mute), .sampleValid(sampleValid), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdata(sdata)
  );

  // {i2sFmt, left, right}
  localparam logic [36:0] VEC [0:5] = '{
    {1'b0, 18'h1FFFF, 18'h20000},
    {1'b0, 18'h00000, 18'h3FFFF},
    {1'b0, 18'h2AAAA, 18'h15555},
    {1'b1, 18'h12345, 18'h0F0F1},
    {1'b1, 18'h20001, 18'h1FFFE},
    {1'b1, 18'h3FFFF, 18'h00001}
  };

  // line monitor: rebuilds the slots as read on rising bit-clock edges
  logic lastB = 0, lastL = 0, inRight = 0;
  logic [31:0] accL = 0, accR = 0;
  int nL = 0, nR = 0;
  logic [31:0] capL = 0, capR = 0;
  int frameCnt = 0;

  always @(negedge clk) begin
    logic mb, ml, leftLvl;
    mb = masterMode ? bclkOut : bclkIn;
    ml = masterMode ? lrclkOut : lrclkIn;
    leftLvl = i2sFmt ? 1'b0 : 1'b1;
    if (!rstN) begin
      nL = 0; nR = 0; accL = 0; accR = 0; inRight = 0;
    end else begin
      if (ml != lastL) begin
        if (ml == leftLvl) begin
          capL <= (nL == 0) ? 32'h0 : accL << (32 - nL);
          capR <= (nR == 0) ? 32'h0 : accR << (32 - nR);
          frameCnt <= frameCnt + 1;
          nL = 0; nR = 0; accL = 0; accR = 0; inRight = 0;
        end else inRight = 1;
      end
      if (mb && !lastB) begin
        if (inRight) begin
          if (nR < 32) begin accR = {accR[30:0], sdata}; nR++; end
        end else begin
          if (nL < 32) begin accL = {accL[30:0], sdata}; nL++; end
        end
      end
    end
    lastB = mb;
    lastL = ml;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] expSlot(input logic fmt, input logic [17:0] w);
    return fmt ? {1'b0, w, 13'h0} : {w, 14'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doReset(input logic fmt, input logic mst);
    rstN <= 1'b0; i2sFmt <= fmt; masterMode <= mst; mute <= 1'b0;
    bclkIn <= 1'b0; lrclkIn <= 1'b0;
    repeat (4) @(negedge clk);
    check("R1 sdata in reset", {31'h0, sdata}, 32'h0);
    check("R1 bclkOut in reset", {31'h0, bclkOut}, 32'h0);
    rstN <= 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [17:0] l, input logic [17:0] r);
    sampleLeft <= l; sampleRight <= r; sampleValid <= 1'b1;
    @(negedge clk);
    sampleValid <= 1'b0;
  endtask

  task automatic waitFrames(input int n);
    int target;
    target = frameCnt + n;
    while (frameCnt < target) @(negedge clk);
  endtask

  task automatic slaveFrames(input int n, input int bitsPerSlot);
    for (int f = 0; f < n; f++)
      for (int ch = 0; ch < 2; ch++)
        for (int b = 0; b < bitsPerSlot; b++) begin
          bclkIn <= 1'b0;
          if (b == 0) lrclkIn <= (ch == 0);
          repeat (6) @(negedge clk);
          bclkIn <= 1'b1;
          repeat (6) @(negedge clk);
        end
  endtask

  initial begin
    logic curFmt;
    int rises, toggles;
    logic pb, pl;

    doReset(1'b0, 1'b1);
    curFmt = 1'b0;

    // R2: clock ratios over a 512-cycle window
    rises = 0; toggles = 0; pb = bclkOut; pl = lrclkOut;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (bclkOut && !pb) rises++;
      if (lrclkOut != pl) toggles++;
      pb = bclkOut; pl = lrclkOut;
    end
    check("R2 bit clocks per 512", rises, 128);
    check("R2 frame edges per 512", toggles, 4);

    // R3 / R4: vector table
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][36] != curFmt) begin
        curFmt = VEC[v][36];
        doReset(curFmt, 1'b1);
      end
      push(VEC[v][35:18], VEC[v][17:0]);
      waitFrames(2);
      check(curFmt ? "R4 left slot" : "R3 left slot", capL, expSlot(curFmt, VEC[v][35:18]));
      check(curFmt ? "R4 right slot" : "R3 right slot", capR, expSlot(curFmt, VEC[v][17:0]));
    end

    // R6 / R7: pair offered mid left slot
    doReset(1'b0, 1'b1);
    push(18'h0AAAA, 18'h31111);
    waitFrames(2);
    repeat (20) @(negedge clk);
    push(18'h05A5A, 18'h3C3C3);
    waitFrames(1);
    check("R6 in-flight left keeps old", capL, expSlot(1'b0, 18'h0AAAA));
    check("R6 in-flight right keeps old", capR, expSlot(1'b0, 18'h31111));
    waitFrames(1);
    check("R6 new pair left", capL, expSlot(1'b0, 18'h05A5A));
    waitFrames(1);
    check("R7 repeated right", capR, expSlot(1'b0, 18'h3C3C3));

    // R9: valid in the same cycle as the left-slot start
    waitFrames(1);           // now one cycle after a left start (counter = 1)
    repeat (254) @(negedge clk);
    begin
      int s;
      s = frameCnt;
      push(18'h13579, 18'h2468A);
      while (frameCnt < s + 2) @(negedge clk);
    end
    check("R9 same-cycle left", capL, expSlot(1'b0, 18'h13579));
    check("R9 same-cycle right", capR, expSlot(1'b0, 18'h2468A));

    // R8: mute
    push(18'h1F00F, 18'h2E0E0);
    mute <= 1'b1;
    waitFrames(2);
    check("R8 muted left", capL, 32'h0);
    check("R8 muted right", capR, 32'h0);
    mute <= 1'b0;
    waitFrames(2);
    check("R8 after unmute", capL, expSlot(1'b0, 18'h1F00F));

    // R5: slave mode, 24 bit clocks per slot
    doReset(1'b0, 1'b0);
    push(18'h2BCDE, 18'h1ABCD);
    check("R5 bclkOut quiet", {30'h0, bclkOut, lrclkOut}, 32'h0);
    slaveFrames(3, 24);
    check("R5 slave left", capL, expSlot(1'b0, 18'h2BCDE));
    check("R5 slave right", capR, expSlot(1'b0, 18'h1ABCD));

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule